// File: doc/BRIEF.md
# Phase-Corrected Motor Duty Register with Unipolar PWM

This block drives one half of an H-bridge for a DC motor that is being phase-locked to a reference. It keeps a 16-bit duty register and turns it into a unipolar PWM waveform. Duty 0 holds the output low, so the motor is off. Full scale holds it high, so the motor runs at full speed. Zero is not a centre point. The PWM carrier comes from the system clock through a prescaler and a free-running carrier counter. With the default parameters and a 250 MHz clock the carrier runs at about 763 Hz.

Before phase correction starts, the duty register takes a preset value while reset is held. The preset is chosen to bring the motor close to the reference speed. After that, every signed phase-error sample that is strobed in corrects the register. A positive error means the motor is lagging and needs more drive. A negative error means it is leading.

There are two correction modes:
- **Step mode** moves the duty by exactly one count toward the correct phase.
- **Proportional mode** adds the error itself, scaled by a power-of-two gain. The gain is a shift left or a shift right.

In both modes the sum is formed wider than the register and then saturated to the unipolar range. A corrected duty value is held back until the next carrier period begins, so no period is cut short.

Top module: `motor_duty_pwm`

## Requirements
- R1: While `rst_n` is low, `pwm_out` is low after the next clock edge. The working duty register and the active duty both take `preset_duty`.
- R2: Within each carrier period of 2^CNT_W carrier counts, `pwm_out` is high for the first `duty >> (DUTY_W-CNT_W)` counts and low for the rest. There are two exceptions: active duty 0 keeps it low for the whole period, and active duty 2^DUTY_W-1 keeps it high for the whole period.
- R3: One carrier period lasts PRESCALE * 2^CNT_W clock cycles. The carrier counter advances once every PRESCALE cycles.
- R4: In step mode (`prop_mode`=0), a strobed error changes the duty by exactly one count, whatever the error's size:
  - a positive error adds one;
  - a negative error subtracts one;
  - zero leaves the duty unchanged.
- R5: In proportional mode (`prop_mode`=1), a strobed error is added to the duty after scaling:
  - with `gain_left`=1 the error is shifted left by `gain_shift`;
  - with `gain_left`=0 it is shifted right arithmetically by `gain_shift`, which rounds toward minus infinity.
- R6: In both modes the new duty saturates at 0 and at 2^DUTY_W-1 and never wraps.
  - A positive error never lowers the duty.
  - A negative error never raises it.
- R7: A duty change takes effect only from the start of the next carrier period. The period in progress keeps the active duty it started with.
- R8: When `err_valid` is low, `err_value`, `prop_mode`, `gain_left` and `gain_shift` have no effect on the duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the preset |
| err_valid | input | 1 | One-cycle strobe marking a new phase-error sample |
| err_value | input | ERR_W | Signed phase error, positive when the motor lags |
| prop_mode | input | 1 | 0 selects step correction, 1 selects proportional |
| gain_left | input | 1 | Proportional gain direction: 1 shifts left, 0 shifts right |
| gain_shift | input | SHIFT_W | Proportional gain shift amount |
| preset_duty | input | DUTY_W | Duty value loaded during reset |
| pwm_out | output | 1 | Unipolar PWM drive for one half-bridge |

## Verification
The assertions assume a synchronous reset, and they treat `err_value`, `prop_mode` and the gain inputs as meaningful only in a cycle where `err_valid` is high. They also assume that `preset_duty` holds steady while reset is asserted, because the duty registers follow it during reset.

The stimulus changes `preset_duty` only inside a reset pulse and raises `err_valid` for single cycles. Error strobes are placed well inside a carrier period, away from its boundary. As a result, each period's expected high time is fixed by the duty value captured at its start. In one test the bench also wiggles the error and mode inputs while the strobe is low.

// File: rtl/motor_pwm_pkg.sv
package motor_pwm_pkg;

   typedef enum logic {
      MODE_STEP = 1'b0,
      MODE_PROP = 1'b1
   } corr_mode_e;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/mpwm_carrier.sv
module mpwm_carrier #(
   parameter int CNT_W    = 16,
   parameter int PRESCALE = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] cnt_o,
   output logic             period_start_o
);

   logic             tick;
   logic [CNT_W-1:0] cnt_q;

   generate
      if (PRESCALE == 1) begin : g_no_pre
         assign tick = 1'b1;
      end else begin : g_pre
         localparam int PRE_W = $clog2(PRESCALE);
         localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
         logic [PRE_W-1:0] pre_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pre_q <= '0;
            end else if (pre_q == PRE_LAST) begin
               pre_q <= '0;
            end else begin
               pre_q <= pre_q + 1'b1;
            end
         end

         assign tick = (pre_q == PRE_LAST);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o          = cnt_q;
   assign period_start_o = tick && (&cnt_q);

endmodule

// File: rtl/mpwm_duty_integ.sv
module mpwm_duty_integ
   import motor_pwm_pkg::*;
#(
   parameter int DUTY_W        = 16,
   parameter int ERR_W         = 16,
   parameter int SHIFT_W       = 4,
   parameter bit LEFT_SHIFT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DUTY_W-1:0] preset_i,
   input  logic              err_valid_i,
   input  logic [ERR_W-1:0]  err_i,
   input  logic              prop_mode_i,
   input  logic              gain_left_i,
   input  logic [SHIFT_W-1:0] gain_shift_i,
   output logic [DUTY_W-1:0] duty_o
);

   localparam int MAX_SH = (1 << SHIFT_W) - 1;
   localparam int WIDE   = max_int(ERR_W + MAX_SH, DUTY_W);
   localparam int SUM_W  = WIDE + 2;
   localparam logic signed [SUM_W-1:0] LIMIT =
      {{(SUM_W-DUTY_W){1'b0}}, {DUTY_W{1'b1}}};

   corr_mode_e               mode;
   logic signed [SUM_W-1:0]  err_ext;
   logic signed [SUM_W-1:0]  scaled;
   logic signed [SUM_W-1:0]  step_delta;
   logic signed [SUM_W-1:0]  delta;
   logic signed [SUM_W-1:0]  duty_ext;
   logic signed [SUM_W-1:0]  sum;
   logic [DUTY_W-1:0]        next_duty;
   logic [DUTY_W-1:0]        duty_q;

   assign mode    = corr_mode_e'(prop_mode_i);
   assign err_ext = {{(SUM_W-ERR_W){err_i[ERR_W-1]}}, err_i};

   generate
      if (LEFT_SHIFT_EN) begin : g_bidir
         assign scaled = gain_left_i ? (err_ext <<< gain_shift_i)
                                     : (err_ext >>> gain_shift_i);
      end else begin : g_right_only
         logic unused_left;
         assign unused_left = gain_left_i;
         assign scaled      = err_ext >>> gain_shift_i;
      end
   endgenerate

   always_comb begin
      if (err_i[ERR_W-1]) begin
         step_delta = '1;
      end else if (|err_i) begin
         step_delta = SUM_W'(1);
      end else begin
         step_delta = '0;
      end
   end

   assign delta    = (mode == MODE_PROP) ? scaled : step_delta;
   assign duty_ext = {{(SUM_W-DUTY_W){1'b0}}, duty_q};
   assign sum      = duty_ext + delta;

   always_comb begin
      if (sum[SUM_W-1]) begin
         next_duty = '0;
      end else if (sum > LIMIT) begin
         next_duty = '1;
      end else begin
         next_duty = sum[DUTY_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         duty_q <= preset_i;
      end else if (err_valid_i) begin
         duty_q <= next_duty;
      end
   end

   assign duty_o = duty_q;

endmodule

// File: rtl/mpwm_shaper.sv
module mpwm_shaper #(
   parameter int DUTY_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DUTY_W-1:0] preset_i,
   input  logic              period_start_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic [DUTY_W-1:0] duty_i,
   output logic [DUTY_W-1:0] act_o,
   output logic              pwm_o
);

   logic [DUTY_W-1:0] act_q;
   logic [CNT_W-1:0]  act_top;
   logic              act_full;
   logic              pwm_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= preset_i;
      end else if (period_start_i) begin
         act_q <= duty_i;
      end
   end

   assign act_top  = act_q[DUTY_W-1 -: CNT_W];
   assign act_full = &act_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pwm_q <= 1'b0;
      end else begin
         pwm_q <= act_full | (cnt_i < act_top);
      end
   end

   assign act_o = act_q;
   assign pwm_o = pwm_q;

endmodule

// File: rtl/motor_duty_pwm.sv
module motor_duty_pwm #(
   parameter int DUTY_W        = 16,
   parameter int ERR_W         = 16,
   parameter int SHIFT_W       = 4,
   parameter int CNT_W         = 16,
   parameter int PRESCALE      = 5,
   parameter bit LEFT_SHIFT_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               err_valid,
   input  logic [ERR_W-1:0]   err_value,
   input  logic               prop_mode,
   input  logic               gain_left,
   input  logic [SHIFT_W-1:0] gain_shift,
   input  logic [DUTY_W-1:0]  preset_duty,
   output logic               pwm_out
);

   generate
      if (CNT_W < 1 || CNT_W > DUTY_W) begin : g_bad_cnt
         $error("CNT_W must lie in 1..DUTY_W");
      end
      if (PRESCALE < 1) begin : g_bad_pre
         $error("PRESCALE must be at least 1");
      end
      if (DUTY_W < 2 || DUTY_W > 30) begin : g_bad_duty
         $error("DUTY_W must lie in 2..30");
      end
      if (ERR_W < 2 || SHIFT_W < 1 || SHIFT_W > 5) begin : g_bad_err
         $error("ERR_W must be at least 2 and SHIFT_W in 1..5");
      end
   endgenerate

   logic [CNT_W-1:0]  cnt;
   logic              period_start;
   logic [DUTY_W-1:0] duty_q;
   logic [DUTY_W-1:0] act_q;

   mpwm_carrier #(
      .CNT_W    (CNT_W),
      .PRESCALE (PRESCALE)
   ) u_carrier (
      .clk            (clk),
      .rst_n          (rst_n),
      .cnt_o          (cnt),
      .period_start_o (period_start)
   );

   mpwm_duty_integ #(
      .DUTY_W        (DUTY_W),
      .ERR_W         (ERR_W),
      .SHIFT_W       (SHIFT_W),
      .LEFT_SHIFT_EN (LEFT_SHIFT_EN)
   ) u_integ (
      .clk          (clk),
      .rst_n        (rst_n),
      .preset_i     (preset_duty),
      .err_valid_i  (err_valid),
      .err_i        (err_value),
      .prop_mode_i  (prop_mode),
      .gain_left_i  (gain_left),
      .gain_shift_i (gain_shift),
      .duty_o       (duty_q)
   );

   mpwm_shaper #(
      .DUTY_W (DUTY_W),
      .CNT_W  (CNT_W)
   ) u_shaper (
      .clk            (clk),
      .rst_n          (rst_n),
      .preset_i       (preset_duty),
      .period_start_i (period_start),
      .cnt_i          (cnt),
      .duty_i         (duty_q),
      .act_o          (act_q),
      .pwm_o          (pwm_out)
   );

endmodule

// File: rtl/motor_duty_pwm_chk.sv
module motor_duty_pwm_chk #(
   parameter int DUTY_W = 16,
   parameter int ERR_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              err_valid,
   input logic              prop_mode,
   input logic [ERR_W-1:0]  err_value,
   input logic              pwm_out,
   input logic [DUTY_W-1:0] duty_q,
   input logic [DUTY_W-1:0] act_q,
   input logic              period_start
);

   AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q == '0) |=> !pwm_out); // R2

   AST_FULL_DUTY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (&act_q) |=> pwm_out); // R2

   AST_STEP_ONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (err_valid && !prop_mode) |=>
         ((duty_q == $past(duty_q)) ||
          (duty_q == $past(duty_q) + 1'b1) ||
          (duty_q == $past(duty_q) - 1'b1))); // R4

   AST_POS_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (err_valid && !err_value[ERR_W-1]) |=> (duty_q >= $past(duty_q))); // R6

   AST_NEG_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (err_valid && err_value[ERR_W-1]) |=> (duty_q <= $past(duty_q))); // R6

   AST_ACT_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      !period_start |=> $stable(act_q)); // R7

   AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !err_valid |=> $stable(duty_q)); // R8

endmodule

bind motor_duty_pwm motor_duty_pwm_chk #(
   .DUTY_W (DUTY_W),
   .ERR_W  (ERR_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .err_valid    (err_valid),
   .prop_mode    (prop_mode),
   .err_value    (err_value),
   .pwm_out      (pwm_out),
   .duty_q       (duty_q),
   .act_q        (act_q),
   .period_start (period_start)
);

// File: tb/motor_duty_pwm_tb.sv
`timescale 1ns/1ps
module motor_duty_pwm_tb;

   localparam int DW   = 16;
   localparam int EW   = 16;
   localparam int SW   = 4;
   localparam int CW   = 6;
   localparam int PER  = 1 << CW;
   localparam int DMAX = (1 << DW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          err_valid = 1'b0;
   logic [EW-1:0] err_value = '0;
   logic          prop_mode = 1'b0;
   logic          gain_left = 1'b0;
   logic [SW-1:0] gain_shift = '0;
   logic [DW-1:0] preset_duty = '0;
   logic          pwm_out;

   always #2 clk = ~clk;

   motor_duty_pwm #(
      .DUTY_W   (DW),
      .ERR_W    (EW),
      .SHIFT_W  (SW),
      .CNT_W    (CW),
      .PRESCALE (1)
   ) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .err_valid   (err_valid),
      .err_value   (err_value),
      .prop_mode   (prop_mode),
      .gain_left   (gain_left),
      .gain_shift  (gain_shift),
      .preset_duty (preset_duty),
      .pwm_out     (pwm_out)
   );

   typedef struct {
      int    exp;
      string tag;
   } exp_t;

   exp_t  sb_q[$];
   int    checks = 0;
   int    fails = 0;
   int    edge_n = 0;
   int    hi_cnt = 0;
   int    model_duty = 0;
   string cur_tag = "R1";
   bit    done = 1'b0;

   function automatic int exp_high(input int d);
      return (d == DMAX) ? PER : (d >> (DW - CW));
   endfunction

   function automatic int clampd(input longint v);
      if (v < 0) return 0;
      if (v > DMAX) return DMAX;
      return int'(v);
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: per-period high-time compared against scoreboard queue
   always begin
      @(posedge clk);
      #1;
      if (rst_n) begin
         edge_n++;
         if (((edge_n - 1) % PER) == 0) hi_cnt = 0;
         hi_cnt += int'(pwm_out);
         if (((edge_n - 1) % PER) == PER - 1) begin
            if (sb_q.size() == 0) begin
               check("R7 scoreboard empty", 1, 0);
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               check(e.tag, hi_cnt, e.exp);
            end
         end
         if ((edge_n % PER) == 0) begin
            exp_t n;
            n.exp = exp_high(model_duty);
            n.tag = cur_tag;
            sb_q.push_back(n);
         end
      end
   end

   task automatic do_reset(input int preset);
      exp_t n;
      @(negedge clk);
      rst_n = 1'b0;
      preset_duty = DW'(preset);
      repeat (3) @(negedge clk);
      check("R1 pwm low in reset", int'(pwm_out), 0);
      sb_q.delete();
      edge_n = 0;
      model_duty = preset;
      n.exp = exp_high(preset);
      n.tag = cur_tag;
      sb_q.push_back(n);
      rst_n = 1'b1;
   endtask

   task automatic send(input int err, input bit prop, input bit left, input int sh);
      longint s;
      do @(negedge clk);
      while (!(((edge_n % PER) >= 4) && ((edge_n % PER) <= 56)));
      err_value  = EW'(err);
      prop_mode  = prop;
      gain_left  = left;
      gain_shift = SW'(sh);
      err_valid  = 1'b1;
      @(negedge clk);
      err_valid = 1'b0;
      if (!prop) begin
         s = (err > 0) ? 1 : ((err < 0) ? -1 : 0);
      end else if (left) begin
         s = longint'(err) <<< sh;
      end else begin
         s = longint'(err) >>> sh;
      end
      model_duty = clampd(longint'(model_duty) + s);
   endtask

   task automatic settle();
      repeat (2 * PER + 4) @(negedge clk);
   endtask

   task automatic measure_period(input int exp);
      int  gap = 0;
      bit  prev = 1'b1;
      bit  seen = 1'b0;
      bit  fin = 1'b0;
      while (!fin) begin
         @(posedge clk);
         #1;
         if (seen) gap++;
         if (pwm_out && !prev) begin
            if (seen) fin = 1'b1;
            seen = 1'b1;
         end
         prev = pwm_out;
      end
      check("R3 carrier period", gap, exp);
   endtask

   initial begin
      cur_tag = "R1";
      do_reset(20479);                // 20479>>10 = 19
      settle();
      cur_tag = "R4";
      send(1, 1'b0, 1'b0, 0);         // 20480 -> 20
      settle();
      send(-7, 1'b0, 1'b0, 0);        // 20479 -> 19
      settle();
      send(1000, 1'b0, 1'b0, 0);      // +1 only -> 20
      settle();
      send(0, 1'b0, 1'b0, 0);         // no change
      settle();
      cur_tag = "R7";
      send(-1, 1'b0, 1'b0, 0);        // visible only from next period
      settle();
      cur_tag = "R3";
      measure_period(PER);

      cur_tag = "R2";
      do_reset(65534);                // 63
      settle();
      send(1, 1'b0, 1'b0, 0);         // full scale -> 64
      settle();
      cur_tag = "R6";
      send(1, 1'b0, 1'b0, 0);         // saturates, no wrap
      settle();
      send(-1, 1'b0, 1'b0, 0);        // 65534 -> 63
      settle();

      cur_tag = "R2";
      do_reset(0);                    // off
      settle();
      cur_tag = "R6";
      send(-1, 1'b0, 1'b0, 0);        // stays at 0
      settle();

      cur_tag = "R5";
      do_reset(32768);                // 32
      settle();
      send(1024, 1'b1, 1'b0, 0);      // 33792 -> 33
      settle();
      send(-4096, 1'b1, 1'b0, 2);     // -1024 -> 32768
      settle();
      send(3, 1'b1, 1'b1, 10);        // +3072 -> 35840 -> 35
      settle();
      send(-5, 1'b1, 1'b0, 1);        // -3 -> 35837 -> 34
      settle();
      send(-32768, 1'b1, 1'b0, 15);   // -1 -> 35836 -> 34
      settle();
      cur_tag = "R6";
      send(30000, 1'b1, 1'b1, 4);     // saturate high -> 64
      settle();
      send(-32768, 1'b1, 1'b1, 3);    // saturate low -> 0
      settle();
      cur_tag = "R8";
      send(20480, 1'b1, 1'b0, 0);     // 20480 -> 20
      settle();
      repeat (40) begin
         @(negedge clk);
         err_value  = 16'h8000;
         prop_mode  = 1'b1;
         gain_left  = 1'b1;
         gain_shift = 4'd15;
      end
      settle();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule